// File: doc/BRIEF.md
# Piecewise-Linear Sensor Code Linearizer

This block turns raw sensor codes into linearized values by evaluating a stored inverse transfer curve. The curve is held as a table of segment endpoints. Each input code is split into a segment index (its upper bits) and a position inside that segment (its lower bits). The output is a straight-line blend of the two endpoints that bound the segment. Because every value in the table is arbitrary, the same table also absorbs gain and offset error: loading scaled and shifted endpoints corrects those errors with no change to the logic.

Samples enter and leave through valid/ready streams and pass through a fixed three-stage pipeline. A separate write port reloads endpoints while samples are flowing. A write only affects samples accepted after the write edge, so a new curve can be installed without draining the pipeline. The upper endpoint of the last segment is stored as an extra entry, giving 2^IDX_W + 1 endpoints in total.

Top module: `lut_interp_linearizer`

## Requirements
- R1: After reset, `m_valid` is low and stays low until a sample has been accepted.
- R2: The input code splits into index `i = s_data[15:6]` and fraction `f = s_data[5:0]`. When `f` is 0, the output equals table entry `i` exactly.
- R3: Table entries are 16-bit two's complement. The output is `T[i] + floor((T[i+1]-T[i])*f / 64)`, evaluated in signed arithmetic and truncated to 16 bits. It always lies between `T[i]` and `T[i+1]`.
- R4: Codes in the top segment (`i = 1023`) interpolate toward entry 1024, which is the extra endpoint at table address 1024.
- R5: While `m_ready` is held high, a sample accepted on clock edge k appears with `m_valid` high after edge k+2, so the pipeline is three registers deep.
- R6: While `m_valid` is high and `m_ready` is low, `m_valid` and `m_data` hold their values.
- R7: `s_ready` is high whenever `m_ready` is high or `m_valid` is low, and it is low while the output is stalled.
- R8: A write of `tbl_wdata` to `tbl_addr` (0..1024) is used by every sample accepted after the write edge. A sample accepted on the same edge as the write still sees the old entry.
- R9: Writes with `tbl_addr` above 1024 are ignored and change no entry.
- R10: Reloading the whole table with an affine image of the curve (gain and offset applied) changes the outputs to the interpolation of the new table, with no other control needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline valid flags |
| s_valid | input | 1 | Input sample present |
| s_ready | output | 1 | Block accepts an input sample on this edge |
| s_data | input | 16 | Raw sensor code: index in bits 15:6, fraction in bits 5:0 |
| m_valid | output | 1 | Output sample present |
| m_ready | input | 1 | Downstream accepts the output sample |
| m_data | output | 16 | Linearized signed result |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 11 | Endpoint address; 0..1024 valid |
| tbl_wdata | input | 16 | Signed endpoint value to store |

## Verification
Suppose the even/odd bank steering is wrong, or an endpoint is stored in the wrong place. Then the output for affected codes leaves the interval between the two stored endpoints, or it misses the exact endpoint value at fraction 0. This shows three edges after the offending sample is accepted. A stage that loses or duplicates its valid flag shows at once as a missing or extra output against the scoreboard. A fault in the stall path shows up as `m_data` changing during a held cycle. A write-timing fault can only be seen on the first sample that targets the rewritten segment, so the stimulus pairs a write with a same-edge sample and then a sample on the next edge. An address that aliases past the end of the table is exposed by checking, after junk writes, the top segments whose entries would be clobbered.

// File: rtl/lut_interp_linearizer.sv
module lut_interp_linearizer #(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 6,
  parameter int DW     = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic [IN_W-1:0]            s_data,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic [DW-1:0]              m_data,
  input  logic                       tbl_we,
  input  logic [IN_W-FRAC_W:0]       tbl_addr,
  input  logic [DW-1:0]              tbl_wdata
);
  localparam int IDX_W  = IN_W - FRAC_W;
  localparam int AW     = IDX_W + 1;
  localparam int LAST   = 2 ** IDX_W;
  localparam int ODD_N  = 2 ** (IDX_W - 1);
  localparam int EVEN_N = ODD_N + 1;
  localparam int PW     = DW + FRAC_W + 2;

  // endpoints split by address parity so i and i+1 come from different banks
  logic [DW-1:0] bank_e [EVEN_N];
  logic [DW-1:0] bank_o [ODD_N];

  logic en;
  assign en      = m_ready | ~m_valid;
  assign s_ready = en;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-2:0] half;
  logic [IDX_W-1:0] ea;
  assign idx  = s_data[IN_W-1:FRAC_W];
  assign half = idx[IDX_W-1:1];
  assign ea   = {1'b0, half} + IDX_W'(idx[0]);

  logic wr_ok;
  assign wr_ok = tbl_we && (tbl_addr <= AW'(LAST));

  always_ff @(posedge clk) begin
    if (wr_ok && !tbl_addr[0]) bank_e[tbl_addr[AW-1:1]] <= tbl_wdata;
    if (wr_ok &&  tbl_addr[0]) bank_o[tbl_addr[AW-2:1]] <= tbl_wdata;
  end

  // stage 1: endpoint read
  logic [DW-1:0]     rd_e, rd_o;
  logic              par1;
  logic [FRAC_W-1:0] frac1;
  logic              v1;

  always_ff @(posedge clk) begin
    if (en) begin
      rd_e  <= bank_e[ea];
      rd_o  <= bank_o[half];
      par1  <= idx[0];
      frac1 <= s_data[FRAC_W-1:0];
    end
  end

  logic signed [DW-1:0] e_lo, e_hi;
  logic signed [DW:0]   diff;
  logic signed [PW-1:0] prod_c;
  assign e_lo   = par1 ? rd_o : rd_e;
  assign e_hi   = par1 ? rd_e : rd_o;
  assign diff   = $signed({e_hi[DW-1], e_hi}) - $signed({e_lo[DW-1], e_lo});
  assign prod_c = PW'(diff) * PW'($signed({1'b0, frac1}));

  // stage 2: slope times fraction
  logic signed [PW-1:0] prod2;
  logic signed [DW-1:0] base2, lo2, hi2;
  logic                 v2;

  always_ff @(posedge clk) begin
    if (en) begin
      prod2 <= prod_c;
      base2 <= e_lo;
      lo2   <= (e_lo < e_hi) ? e_lo : e_hi;
      hi2   <= (e_lo < e_hi) ? e_hi : e_lo;
    end
  end

  // stage 3: add and register
  logic signed [PW-1:0] step;
  assign step = prod2 >>> FRAC_W;

  always_ff @(posedge clk) begin
    if (en) m_data <= base2 + step[DW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1      <= 1'b0;
      v2      <= 1'b0;
      m_valid <= 1'b0;
    end else if (en) begin
      v1      <= s_valid;
      v2      <= v1;
      m_valid <= v2;
    end
  end

  assert_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && $past(en)) |->
      ($signed(m_data) >= $past(lo2)) && ($signed(m_data) <= $past(hi2)));

  assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && m_ready) ##1 m_ready ##1 m_ready |=> m_valid);

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
    m_ready |-> s_ready);

endmodule

// File: tb/lut_interp_linearizer_tb.sv
module lut_interp_linearizer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [15:0] s_data = '0;
  logic        m_valid;
  logic        m_ready = 1'b1;
  logic [15:0] m_data;
  logic        tbl_we = 1'b0;
  logic [10:0] tbl_addr = '0;
  logic [15:0] tbl_wdata = '0;

  always #10 clk = ~clk;

  lut_interp_linearizer u_dut (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata)
  );

  int checks = 0;
  int errors = 0;
  int model [0:1024];
  logic [15:0] exp_q[$];
  string       tag_q[$];
  bit          stall_mode = 0;
  int          cyc = 0;

  function automatic int curve_a(int k);
    return k * 40 - 20000 - (k * k) / 80;
  endfunction

  function automatic int curve_b(int k);
    return (curve_a(k) * 3) / 4 + 500;
  endfunction

  function automatic logic [15:0] expect_of(logic [15:0] x);
    int i, f, a, b, r;
    i = int'(x[15:6]);
    f = int'(x[5:0]);
    a = model[i];
    b = model[i + 1];
    r = a + (((b - a) * f) >>> 6);
    return r[15:0];
  endfunction

  task automatic check(bit ok, string req, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr(int addr, int val);
    logic [15:0] v;
    v = val[15:0];
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = addr[10:0]; tbl_wdata = v;
    @(posedge clk); #1;
    tbl_we = 1'b0;
    if (addr <= 1024) model[addr] = int'($signed(v));
  endtask

  task automatic send(logic [15:0] x, string tag);
    @(negedge clk);
    s_valid = 1'b1; s_data = x;
    #3;
    while (!s_ready) begin @(negedge clk); #3; end
    exp_q.push_back(expect_of(x));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    s_valid = 1'b0;
  endtask

  task automatic send_with_write(logic [15:0] x, int addr, int val, string tag);
    logic [15:0] v;
    v = val[15:0];
    @(negedge clk);
    s_valid = 1'b1; s_data = x;
    tbl_we = 1'b1; tbl_addr = addr[10:0]; tbl_wdata = v;
    #3;
    check(s_ready == 1'b1, "R8 ready for same-edge write", int'(s_ready), 1);
    exp_q.push_back(expect_of(x));
    tag_q.push_back(tag);
    @(posedge clk); #1;
    s_valid = 1'b0; tbl_we = 1'b0;
    model[addr] = int'($signed(v));
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (exp_q.size() != 0 && n < 2000) begin @(negedge clk); n++; end
    check(exp_q.size() == 0, "drain", exp_q.size(), 0);
  endtask

  initial forever begin
    @(negedge clk);
    cyc++;
    m_ready = stall_mode ? ((cyc % 3) != 1) : 1'b1;
  end

  // monitor / scoreboard
  bit          held = 0;
  logic [15:0] held_data;
  initial forever begin
    @(negedge clk); #3;
    if (rst_n) begin
      if (held) begin
        check(m_valid == 1'b1, "R6 valid held", int'(m_valid), 1);
        check(m_data == held_data, "R6 data held", int'(m_data), int'(held_data));
      end
      held = 0;
      if (m_valid && !m_ready) begin
        held = 1; held_data = m_data;
        check(s_ready == 1'b0, "R7 ready low in stall", int'(s_ready), 0);
      end
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R1 unexpected output", int'(m_data), -1);
        end else begin
          logic [15:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(m_data == e, t, int'($signed(m_data)), int'($signed(e)));
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    check(m_valid == 1'b0, "R1 valid in reset", int'(m_valid), 0);
    rst_n = 1'b1;
    @(negedge clk); #3;
    check(m_valid == 1'b0, "R1 valid after reset", int'(m_valid), 0);
    check(s_ready == 1'b1, "R7 ready when empty", int'(s_ready), 1);

    for (int k = 0; k <= 1024; k++) wr(k, curve_a(k));
    repeat (4) @(negedge clk);
    check(m_valid == 1'b0, "R1 no output without input", int'(m_valid), 0);

    // R2: fraction zero hits endpoints exactly
    send(16'h0000, "R2 endpoint 0");
    send({10'd1, 6'd0}, "R2 endpoint 1");
    send({10'd511, 6'd0}, "R2 endpoint 511");
    send({10'd512, 6'd0}, "R2 endpoint 512");
    send({10'd1023, 6'd0}, "R2 endpoint 1023");
    drain();

    // R3: assorted codes
    lfsr = 16'hACE1;
    for (int n = 0; n < 200; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr, "R3 interpolation");
    end
    send({10'd300, 6'd63}, "R3 fraction max");
    send({10'd7, 6'd32}, "R3 midpoint");
    drain();

    // R4: top segment uses the extra endpoint
    send(16'hFFC0, "R4 top segment start");
    send(16'hFFC1, "R4 top segment +1");
    send(16'hFFFF, "R4 top code");
    drain();

    // R5: latency
    @(negedge clk);
    s_valid = 1'b1; s_data = {10'd40, 6'd10};
    exp_q.push_back(expect_of(s_data)); tag_q.push_back("R5 latency data");
    @(posedge clk); #1; s_valid = 1'b0;
    @(negedge clk); #2;
    check(m_valid == 1'b0, "R5 not valid after 1 edge", int'(m_valid), 0);
    @(negedge clk); #2;
    check(m_valid == 1'b0, "R5 not valid after 2 edges", int'(m_valid), 0);
    @(negedge clk); #2;
    check(m_valid == 1'b1, "R5 valid after 3 edges", int'(m_valid), 1);
    drain();

    // R6/R7: backpressure
    stall_mode = 1;
    for (int n = 0; n < 60; n++) send({n[9:0] * 10'd17, n[5:0]}, "R6 under stall");
    drain();
    stall_mode = 0;
    repeat (2) @(negedge clk);

    // R8: same-edge write returns old entry, next sample sees new one
    send_with_write({10'd5, 6'd0}, 5, 1234, "R8 same-edge old value");
    send({10'd5, 6'd0}, "R8 next sample new value");
    send({10'd4, 6'd40}, "R8 neighbour segment");
    drain();

    // R9: out-of-range writes ignored
    wr(1025, 16'h7777);
    wr(2047, 16'h1111);
    wr(1536, 16'h2222);
    send({10'd1023, 6'd32}, "R9 top entries intact");
    send({10'd1022, 6'd50}, "R9 entry 1023 intact");
    send({10'd0, 6'd20}, "R9 entry 0 intact");
    send({10'd512, 6'd5}, "R9 entry 512 intact");
    drain();

    // R10: gain/offset folded into reloaded table
    for (int k = 0; k <= 1024; k++) wr(k, curve_b(k));
    lfsr = 16'h1D2B;
    for (int n = 0; n < 60; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      send(lfsr, "R10 corrected table");
    end
    send(16'hFFFF, "R10 top code");
    drain();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule